// File: doc/BRIEF.md
# Four-Slot Transmit Descriptor Engine

This block is the device side of a transmit path that the host drives through four fixed descriptor slots. Each slot is a pair of registers: a start address and a combined command/status word. The host fills in a slot's address and then writes its status word with a frame length and an early-start threshold. That write hands the slot to the engine. The engine always serves slots in ring order 0, 1, 2, 3, 0, and so on. It fetches the frame one byte at a time through a simple memory-read port into an internal FIFO. Once enough bytes are buffered, it streams them out on a byte-wide MAC transmit interface.

When a slot finishes, the engine writes the outcome back into the same status word and pulses one of two interrupt lines. Bit 13 of the word shows that the frame is fully copied. The word also carries success, underrun and abort flags, and a collision count taken from a collision strobe on the MAC side. The host reads the words back over the same register port.

Top module: `tx_slot_engine`

## Requirements
- R1: A write to status word 0x10+4*i (i = 0..3) of an idle slot loads the length into bits 12:0 and the threshold into bits 20:16. It clears own (bit 13), underrun (bit 14), complete-OK (bit 15), abort (bit 30) and the collision count (bits 27:24), and queues the slot. Bits 31, 29, 28 and 23:21 read as zero.
- R2: A write to address register 0x20+4*i stores the address with bits 1:0 forced to zero. The register reads back the same way.
- R3: Slots are served strictly in ring order. A queued slot waits until every slot ahead of it in the ring has retired, and the ring wraps from slot 3 to slot 0.
- R4: The bytes presented on tx_data are those at start address + 0, +1, ... in order, one per tx_valid/tx_ready handshake. tx_last is high only with the final byte.
- R5: No byte is presented before at least min(threshold*32, length, FIFO depth) bytes of the frame have been fetched.
- R6: Own (bit 13) is set as soon as every byte of the frame has been copied into the FIFO, even if none has yet left.
- R7: When the final byte is accepted, complete-OK (bit 15) is set and irq_tx_ok pulses for one cycle.
- R8: If the FIFO is empty while the MAC is ready, the frame has started and bytes remain, the engine sets underrun and own, pulses irq_tx_err, ends the frame, and neither sends nor fetches any more of it.
- R9: Each tx_coll pulse during a frame increments the slot's collision count (bits 27:24), which saturates at 15.
- R10: A 16th collision aborts the frame. It sets abort (bit 30) and own, pulses irq_tx_err, and drops any buffered bytes unsent.
- R11: A slot queued with length zero retires as complete-OK with own set. It sends no byte and issues no memory read.
- R12: After reset all slot registers read zero, and tx_valid, rd_req and both interrupt lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address (write and read) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| rd_req | output | 1 | Memory byte read request |
| rd_addr | output | 32 | Memory byte address |
| rd_ack | input | 1 | Memory returns rd_data this cycle |
| rd_data | input | 8 | Memory read byte |
| tx_valid | output | 1 | Byte available to MAC |
| tx_data | output | 8 | Byte to MAC |
| tx_last | output | 1 | Final byte of the frame |
| tx_ready | input | 1 | MAC accepts a byte / demands data |
| tx_coll | input | 1 | Collision strobe from MAC |
| irq_tx_ok | output | 1 | One-cycle pulse on successful completion |
| irq_tx_err | output | 1 | One-cycle pulse on underrun or abort |

## Verification
A status write becomes visible on reg_rdata in the cycle that follows its clock edge. Fetching starts two cycles after the write, and own appears one cycle after the final fetch handshake. A retirement updates the status word and raises its interrupt pulse on the same edge, so both can be seen in the next cycle. The bench drives inputs on the falling edge. It samples outputs a quarter period later, when all outputs and the bench-driven handshakes have settled. A scoreboard pairs every accepted byte and every interrupt pulse with the item expected at that point. Status words are read back only after the expected queues have drained, or after a fixed wait that is longer than the fetch needs.

// File: rtl/tx_slot_engine.sv
module tx_slot_engine #(
  parameter int FIFO_DEPTH = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        rd_req,
  output logic [31:0] rd_addr,
  input  logic        rd_ack,
  input  logic [7:0]  rd_data,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  output logic        tx_last,
  input  logic        tx_ready,
  input  logic        tx_coll,
  output logic        irq_tx_ok,
  output logic        irq_tx_err
);
  localparam int FAW = $clog2(FIFO_DEPTH);
  localparam int NS  = 4;
  localparam logic [FAW:0] FULL = (FAW+1)'(FIFO_DEPTH);

  logic [12:0] st_size [NS];
  logic [4:0]  st_thr  [NS];
  logic [3:0]  st_ncc  [NS];
  logic [29:0] st_addr [NS];
  logic [NS-1:0] st_own, st_tun, st_tok, st_abt, queued;

  logic [1:0]  idx;
  logic        run, started;
  logic [12:0] fcnt, scnt;
  logic [FAW:0] cnt;
  logic [FAW-1:0] wp, rp;
  logic [7:0]  fifo [FIFO_DEPTH];

  wire [1:0]  wslot  = reg_addr[3:2];
  wire        wr_st  = reg_wr && reg_addr[7:4] == 4'h1 && reg_addr[1:0] == 2'b00;
  wire        wr_ad  = reg_wr && reg_addr[7:4] == 4'h2 && reg_addr[1:0] == 2'b00;
  wire [12:0] cur_size = st_size[idx];
  wire [12:0] last_ix  = 13'(cur_size - 13'd1);
  wire [13:0] thr_bytes = {4'b0, st_thr[idx], 5'b0};

  assign rd_req   = run && fcnt < cur_size && cnt != FULL;
  assign rd_addr  = {st_addr[idx], 2'b00} + 32'(fcnt);
  assign tx_valid = started && cnt != '0;
  assign tx_data  = fifo[rp];
  assign tx_last  = tx_valid && scnt == last_ix;

  wire push      = rd_req && rd_ack;
  wire pop       = tx_valid && tx_ready;
  wire start_now = run && !started && cnt != '0 &&
                   (14'(cnt) >= thr_bytes || cnt == FULL || fcnt == cur_size);
  wire underrun  = run && started && tx_ready && cnt == '0 && scnt < cur_size;
  wire coll_abt  = run && tx_coll && st_ncc[idx] == 4'd15;
  wire last_pop  = pop && scnt == last_ix;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr[1:0] == 2'b00) begin
      if (reg_addr[7:4] == 4'h1)
        reg_rdata = {1'b0, st_abt[wslot], 2'b00, st_ncc[wslot], 3'b000, st_thr[wslot],
                     st_tok[wslot], st_tun[wslot], st_own[wslot], st_size[wslot]};
      else if (reg_addr[7:4] == 4'h2)
        reg_rdata = {st_addr[wslot], 2'b00};
    end
  end

  always_ff @(posedge clk)
    if (push) fifo[wp] <= rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NS; i++) begin
        st_size[i] <= '0;
        st_thr[i]  <= '0;
        st_ncc[i]  <= '0;
        st_addr[i] <= '0;
      end
      st_own <= '0; st_tun <= '0; st_tok <= '0; st_abt <= '0; queued <= '0;
      idx <= '0; run <= 1'b0; started <= 1'b0;
      fcnt <= '0; scnt <= '0; cnt <= '0; wp <= '0; rp <= '0;
      irq_tx_ok <= 1'b0; irq_tx_err <= 1'b0;
    end else begin
      irq_tx_ok  <= 1'b0;
      irq_tx_err <= 1'b0;
      // writes to a slot still owned by the engine are dropped
      if (wr_st && !queued[wslot]) begin
        st_size[wslot] <= reg_wdata[12:0];
        st_thr[wslot]  <= reg_wdata[20:16];
        st_ncc[wslot]  <= '0;
        st_own[wslot]  <= 1'b0;
        st_tun[wslot]  <= 1'b0;
        st_tok[wslot]  <= 1'b0;
        st_abt[wslot]  <= 1'b0;
        queued[wslot]  <= 1'b1;
      end
      if (wr_ad) st_addr[wslot] <= reg_wdata[31:2];

      if (!run) begin
        if (queued[idx]) begin
          if (cur_size == '0) begin
            st_own[idx] <= 1'b1;
            st_tok[idx] <= 1'b1;
            queued[idx] <= 1'b0;
            irq_tx_ok   <= 1'b1;
            idx         <= idx + 2'd1;
          end else begin
            run  <= 1'b1;
            fcnt <= '0;
            scnt <= '0;
          end
        end
      end else begin
        if (push) begin
          fcnt <= fcnt + 13'd1;
          wp   <= wp + 1'b1;
          if (fcnt == last_ix) st_own[idx] <= 1'b1;
        end
        if (pop) begin
          rp   <= rp + 1'b1;
          scnt <= scnt + 13'd1;
        end
        cnt <= cnt + (FAW+1)'(push) - (FAW+1)'(pop);
        if (start_now) started <= 1'b1;
        if (tx_coll && st_ncc[idx] != 4'd15) st_ncc[idx] <= st_ncc[idx] + 4'd1;

        if (coll_abt || underrun || last_pop) begin
          if (coll_abt) begin
            st_abt[idx] <= 1'b1;
            st_own[idx] <= 1'b1;
            irq_tx_err  <= 1'b1;
          end else if (underrun) begin
            st_tun[idx] <= 1'b1;
            st_own[idx] <= 1'b1;
            irq_tx_err  <= 1'b1;
          end else begin
            st_tok[idx] <= 1'b1;
            irq_tx_ok   <= 1'b1;
          end
          queued[idx] <= 1'b0;
          idx     <= idx + 2'd1;
          run     <= 1'b0;
          started <= 1'b0;
          cnt <= '0; wp <= '0; rp <= '0;
        end
      end
    end
  end

  wire [1:0] prev = 2'(idx - 2'd1);

  a_r3_retire_advances: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_tx_ok || irq_tx_err) |-> idx == 2'($past(idx) + 2'd1));
  a_r3_retired_slot_released: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_tx_ok || irq_tx_err) |-> !queued[prev]);
  a_r7_ok_flags: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tx_ok |-> (st_tok[prev] && st_own[prev] && !st_tun[prev] && !st_abt[prev]));
  a_r8_err_flags: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tx_err |-> (st_own[prev] && (st_tun[prev] || st_abt[prev]) && !st_tok[prev]));
  a_r7_single_irq: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_tx_ok && irq_tx_err));
  a_r5_fifo_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL);
  a_r4_send_only_owned: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (run && queued[idx]));
  a_r6_no_fetch_after_own: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> !st_own[idx]);
endmodule

// File: tb/tx_slot_engine_tb_top.sv
module tx_slot_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        rd_req, rd_ack = 1'b0;
  logic [31:0] rd_addr;
  logic [7:0]  rd_data = '0;
  logic        tx_valid, tx_last, tx_ready = 1'b1, tx_coll = 1'b0;
  logic [7:0]  tx_data;
  logic        irq_tx_ok, irq_tx_err;

  always #10 clk = ~clk;

  tx_slot_engine dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rd_req(rd_req),
    .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
    .tx_ready(tx_ready), .tx_coll(tx_coll),
    .irq_tx_ok(irq_tx_ok), .irq_tx_err(irq_tx_err));

  logic [7:0] mem [4096];
  logic [8:0] exp_bytes [$];
  bit         exp_done [$];
  int n_checks = 0, n_fail = 0;
  int src_budget = -1;
  int fetched = 0, thr_min = 0;
  bit seen_tx = 1'b0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // memory model: answers on the falling edge, consumed at the next rising edge
  always @(negedge clk) begin
    rd_ack  = rd_req && (src_budget != 0);
    rd_data = mem[rd_addr[11:0]];
    if (rd_ack && src_budget > 0) src_budget--;
  end

  // monitor: samples a quarter period after the falling edge
  always begin
    @(negedge clk);
    #5;
    if (rst_n) begin
      if (tx_valid && !seen_tx) begin
        seen_tx = 1'b1;
        if (thr_min > 0) chk(fetched >= thr_min, "R5 bytes buffered before first send", fetched, thr_min);
      end
      if (tx_valid && tx_ready) begin
        if (exp_bytes.size() == 0) chk(1'b0, "R4 unexpected byte", {23'b0, tx_last, tx_data}, 0);
        else begin
          logic [8:0] e;
          e = exp_bytes.pop_front();
          chk({tx_last, tx_data} == e, "R4 byte/last", {23'b0, tx_last, tx_data}, {23'b0, e});
        end
      end
      if (rd_req && rd_ack) fetched++;
      if (irq_tx_ok || irq_tx_err) begin
        if (exp_done.size() == 0) chk(1'b0, "R7 unexpected completion", {30'b0, irq_tx_err, irq_tx_ok}, 0);
        else begin
          bit e;
          e = exp_done.pop_front();
          chk(irq_tx_err == e && irq_tx_ok == !e, "R7 R8 completion kind",
              {30'b0, irq_tx_err, irq_tx_ok}, {30'b0, e, !e});
        end
        seen_tx = 1'b0;
        fetched = 0;
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic expect_frame(input int base, input int size, input int nsent, input bit err);
    for (int k = 0; k < nsent; k++)
      exp_bytes.push_back({(k == size - 1), mem[(base + k) % 4096]});
    exp_done.push_back(err);
  endtask

  task automatic queue_slot(input int slot, input int size, input int thr);
    wr(8'(8'h10 + 4 * slot), (32'(thr) << 16) | 32'(size));
  endtask

  task automatic wait_drain(input string req);
    int t = 0;
    while ((exp_bytes.size() != 0 || exp_done.size() != 0) && t < 5000) begin
      @(negedge clk);
      t++;
    end
    chk(t < 5000, req, t, 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_coll(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tx_coll = 1'b1;
      @(negedge clk); tx_coll = 1'b0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 4096; i++) mem[i] = 8'((i * 7 + 3) ^ (i >> 8));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R12 reset state
    for (int s = 0; s < 4; s++) begin
      rd(8'(8'h10 + 4 * s), v); chk(v == 0, "R12 status after reset", v, 0);
      rd(8'(8'h20 + 4 * s), v); chk(v == 0, "R12 address after reset", v, 0);
    end
    chk(!tx_valid && !rd_req && !irq_tx_ok && !irq_tx_err, "R12 outputs idle",
        {28'b0, tx_valid, rd_req, irq_tx_ok, irq_tx_err}, 0);

    // R2 alignment
    wr(8'h20, 32'h0000_0103);
    rd(8'h20, v); chk(v == 32'h100, "R2 address low bits dropped", v, 32'h100);
    wr(8'h24, 32'h200); wr(8'h28, 32'h400); wr(8'h2C, 32'h600);

    // R4 R7 basic frame on slot 0
    expect_frame(32'h100, 10, 10, 1'b0);
    queue_slot(0, 10, 0);
    wait_drain("R4 slot0 drain");
    rd(8'h10, v); chk(v == 32'h0000_A00A, "R7 slot0 status", v, 32'h0000_A00A);

    // R1 R5 long frame with threshold 4 (128 bytes)
    thr_min = 128;
    expect_frame(32'h200, 300, 300, 1'b0);
    queue_slot(1, 300, 4);
    rd(8'h14, v); chk(v == 32'h0004_012C, "R1 fields loaded, flags clear", v, 32'h0004_012C);
    wait_drain("R5 slot1 drain");
    thr_min = 0;
    rd(8'h14, v); chk(v == 32'h0004_A12C, "R7 slot1 status", v, 32'h0004_A12C);

    // R6 own set while MAC holds off
    tx_ready = 1'b0;
    expect_frame(32'h400, 10, 10, 1'b0);
    queue_slot(2, 10, 0);
    repeat (30) @(negedge clk);
    rd(8'h18, v); chk(v == 32'h0000_200A, "R6 own after copy, not yet sent", v, 32'h0000_200A);
    tx_ready = 1'b1;
    wait_drain("R6 slot2 drain");
    rd(8'h18, v); chk(v == 32'h0000_A00A, "R7 slot2 status", v, 32'h0000_A00A);

    // R11 zero-length slot 3
    expect_frame(32'h600, 0, 0, 1'b0);
    queue_slot(3, 0, 0);
    wait_drain("R11 slot3 drain");
    rd(8'h1C, v); chk(v == 32'h0000_A000, "R11 zero length status", v, 32'h0000_A000);

    // R3 wrap to slot 0, R8 underrun after 40 bytes
    src_budget = 40;
    expect_frame(32'h100, 100, 40, 1'b1);
    queue_slot(0, 100, 1);
    wait_drain("R8 underrun drain");
    rd(8'h10, v); chk(v == 32'h0001_6064, "R8 underrun status", v, 32'h0001_6064);
    chk(!rd_req && !tx_valid, "R8 no further fetch or send", {30'b0, rd_req, tx_valid}, 0);
    src_budget = -1;

    // R9 collision count
    expect_frame(32'h200, 50, 50, 1'b0);
    queue_slot(1, 50, 0);
    repeat (10) @(negedge clk);
    pulse_coll(3);
    wait_drain("R9 slot1 drain");
    rd(8'h14, v); chk(v == 32'h0300_A032, "R9 collision count", v, 32'h0300_A032);

    // R10 abort on 16th collision
    tx_ready = 1'b0;
    expect_frame(32'h400, 20, 0, 1'b1);
    queue_slot(2, 20, 0);
    repeat (3) @(negedge clk);
    pulse_coll(16);
    wait_drain("R10 abort drain");
    tx_ready = 1'b1;
    repeat (5) @(negedge clk);
    chk(!tx_valid, "R10 buffered bytes dropped", {31'b0, tx_valid}, 0);
    rd(8'h18, v); chk(v == 32'h4F00_2014, "R10 abort status", v, 32'h4F00_2014);

    // R3 strict order: slot 0 queued before slot 3 must wait
    expect_frame(32'h600, 8, 8, 1'b0);
    expect_frame(32'h100, 8, 8, 1'b0);
    queue_slot(0, 8, 0);
    repeat (20) @(negedge clk);
    chk(!rd_req && !tx_valid, "R3 out-of-turn slot waits", {30'b0, rd_req, tx_valid}, 0);
    rd(8'h10, v); chk(v == 32'h0000_0008, "R3 waiting slot untouched", v, 32'h0000_0008);
    queue_slot(3, 8, 0);
    wait_drain("R3 in-order drain");
    rd(8'h10, v); chk(v == 32'h0000_A008, "R3 slot0 done after slot3", v, 32'h0000_A008);
    rd(8'h1C, v); chk(v == 32'h0000_A008, "R3 slot3 status", v, 32'h0000_A008);

    chk(exp_bytes.size() == 0 && exp_done.size() == 0, "R4 scoreboard empty",
        32'(exp_bytes.size()), 0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule